// File: doc/BRIEF.md
# DDR Burst Column Sequencer

This block sits on the controller side of a double-data-rate memory whose row is already open. It accepts read, write and precharge requests through a valid/ready handshake. For each accepted read or write it drives the column command and then produces the column address of every data beat. Two beats move per clock cycle, one on each clock edge, so a burst of BL beats takes BL/2 cycles. Beat addresses run in sequential order and wrap inside an aligned boundary whose size is the burst length. The column bits above that boundary do not change.

When a new request arrives while more than two beats of the current burst are still to come, the block picks a way to cut the burst short. Read after read, write after write and precharge after read are issued at once. Write after read goes through a burst-stop command and a wait. Leaving a write early masks the write beats that are still in flight and waits a set latency, counted from the last beat actually written. While a wait runs, the block holds `busy` high and refuses new requests. If exactly one beat pair is still to come, the request is held for one cycle so that the burst ends normally. The next command then follows with no gap.

Top module: `ddr_burst_seq`

## Requirements
- R1: Only `bl_cfg` values 2, 4 and 8 are legal. With any other value `req_ready` is low, and no command or beat starts.
- R2: A request is accepted on a clock edge where `req_valid`, `req_ready` and a nonzero `req_cmd` are all present (1 = read, 2 = write, 3 = precharge; 0 is ignored). In an idle block the command appears on `mem_cmd` in the next cycle (0 = no-op, 1 = read, 2 = write, 3 = precharge, 4 = burst stop). `mem_col` carries the start column for a read or write and is 0 otherwise. After reset `mem_cmd` is 0 and `beat_valid`, `dm` and `busy` are low.
- R3: In the cycle a read or write command appears, and in each following cycle of the burst, `beat_valid` is high and `beat_col0`/`beat_col1` give two consecutive beat columns. The low log2(BL) bits start at the start column and count up by one per beat, wrapping to 0 at the boundary. For example, start 5 with BL 8 gives 5,6,7,0,1,2,3,4.
- R4: The column bits above the burst boundary equal those of the start column for every beat. `beat_wr` is high for write bursts.
- R5: With more than two beats still to come after the current cycle, a read interrupting a read, a write interrupting a write, or a precharge interrupting a read appears in the next cycle. That command ends the old burst at once.
- R6: A write interrupting a read puts burst stop (4) on `mem_cmd` in the next cycle, and read beats stop in that cycle. The write follows T_BSTW cycles after the burst stop, with no-ops in between.
- R7: A read interrupting a write at cycle c appears at cycle c+T_WRD. Write beats up to that point continue with `dm` high.
- R8: A precharge interrupting a write at cycle c appears at cycle c+T_DPL. The write beats in between are masked the same way.
- R9: When exactly two beats remain after the current cycle, `req_ready` is low. In the following cycle, which holds the last beat pair, a request is accepted, and its command appears right after the burst with no gap.
- R10: `busy` is high while a burst is presenting beats or a latency wait is running. `req_ready` is low during a wait.
- R11: `dm` is high only on write beats after an interrupt point, and it is low from the cycle the next command appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bl_cfg | input | 4 | Programmed burst length in beats |
| req_valid | input | 1 | Request present |
| req_cmd | input | 2 | Request kind: 1 read, 2 write, 3 precharge |
| req_col | input | COL_W | Start column of the request |
| req_ready | output | 1 | Request can be taken this cycle |
| mem_cmd | output | 3 | Command toward memory: 0 no-op, 1 read, 2 write, 3 precharge, 4 burst stop |
| mem_col | output | COL_W | Column sent with a read or write command |
| beat_valid | output | 1 | A beat pair is presented this cycle |
| beat_wr | output | 1 | The current beats belong to a write |
| beat_col0 | output | COL_W | Column of the rising-edge beat |
| beat_col1 | output | COL_W | Column of the falling-edge beat |
| dm | output | 1 | Data mask for the current write beats |
| busy | output | 1 | Burst or latency wait in progress |

## Verification
The bench builds the block with an 8-bit column, a burst-stop-to-write latency of 2, a write-to-read latency of 3 and a data-to-precharge latency of 2. Every one of these latencies is larger than one cycle, so the burst-stop gap, masked write beats during both write exits, and the held-off handshake during waits can all be observed. The 8-bit column leaves upper bits above even the 8-beat boundary, so wrapping inside the boundary can be told apart from carrying into the bits above it.

// File: rtl/ddr_burst_seq.sv
module ddr_burst_seq #(
  parameter int COL_W  = 8,
  parameter int BLW    = 4,
  parameter int T_BSTW = 2,
  parameter int T_WRD  = 2,
  parameter int T_DPL  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BLW-1:0]   bl_cfg,
  input  logic             req_valid,
  input  logic [1:0]       req_cmd,
  input  logic [COL_W-1:0] req_col,
  output logic             req_ready,
  output logic [2:0]       mem_cmd,
  output logic [COL_W-1:0] mem_col,
  output logic             beat_valid,
  output logic             beat_wr,
  output logic [COL_W-1:0] beat_col0,
  output logic [COL_W-1:0] beat_col1,
  output logic             dm,
  output logic             busy
);
  localparam int TM1  = (T_WRD > T_DPL) ? T_WRD : T_DPL;
  localparam int TMAX = (T_BSTW > TM1) ? T_BSTW : TM1;
  localparam int CW   = $clog2(TMAX + 1);
  localparam logic [2:0] C_NOP = 3'd0, C_WR = 3'd2, C_BST = 3'd4;
  localparam logic [1:0] Q_RD = 2'd1, Q_WR = 2'd2, Q_PRE = 2'd3;

  logic [2:0]       cmd_q;
  logic [COL_W-1:0] col_q, base_q, off_q, pend_col;
  logic [BLW-1:0]   bl_q, rem_q, pend_bl;
  logic [1:0]       pend_cmd;
  logic             act_q, wr_q, dm_q, wait_q;
  logic [CW-1:0]    cnt_q;

  logic             bl_ok, accept, iss, go_bst, go_mask;
  logic [1:0]       iss_cmd;
  logic [COL_W-1:0] iss_col, mask, hi;
  logic [BLW-1:0]   iss_bl;
  logic [CW-1:0]    t_load;

  assign bl_ok     = (bl_cfg == BLW'(2)) || (bl_cfg == BLW'(4)) || (bl_cfg == BLW'(8));
  assign req_ready = !wait_q && !(act_q && rem_q == BLW'(2)) && bl_ok;
  assign accept    = req_valid && req_ready && (req_cmd != 2'd0);
  assign mask      = COL_W'(bl_q) - COL_W'(1);
  assign hi        = base_q & ~mask;

  assign mem_cmd    = cmd_q;
  assign mem_col    = col_q;
  assign beat_valid = act_q;
  assign beat_wr    = act_q & wr_q;
  assign beat_col0  = act_q ? (hi | off_q) : '0;
  assign beat_col1  = act_q ? (hi | ((off_q + COL_W'(1)) & mask)) : '0;
  assign dm         = dm_q & act_q & wr_q;
  assign busy       = act_q | wait_q;

  always_comb begin
    iss     = 1'b0;
    go_bst  = 1'b0;
    go_mask = 1'b0;
    iss_cmd = req_cmd;
    iss_col = req_col;
    iss_bl  = bl_cfg;
    t_load  = CW'(T_BSTW);
    if (wait_q) begin
      iss_cmd = pend_cmd;
      iss_col = pend_col;
      iss_bl  = pend_bl;
      iss     = (cnt_q == CW'(1));
    end else if (accept) begin
      if (!act_q || rem_q == '0) begin
        iss = 1'b1;
      end else if (!wr_q && req_cmd == Q_WR) begin
        go_bst = 1'b1;
      end else if (wr_q && req_cmd != Q_WR) begin
        t_load = (req_cmd == Q_RD) ? CW'(T_WRD - 1) : CW'(T_DPL - 1);
        if (t_load == '0) iss = 1'b1;
        else go_mask = 1'b1;
      end else begin
        iss = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= C_NOP;
      col_q    <= '0;
      base_q   <= '0;
      off_q    <= '0;
      bl_q     <= BLW'(2);
      rem_q    <= '0;
      act_q    <= 1'b0;
      wr_q     <= 1'b0;
      dm_q     <= 1'b0;
      wait_q   <= 1'b0;
      cnt_q    <= '0;
      pend_cmd <= '0;
      pend_col <= '0;
      pend_bl  <= BLW'(2);
    end else begin
      cmd_q <= C_NOP;
      col_q <= '0;
      if (iss) begin
        cmd_q  <= {1'b0, iss_cmd};
        col_q  <= (iss_cmd == Q_PRE) ? '0 : iss_col;
        act_q  <= (iss_cmd != Q_PRE);
        wr_q   <= (iss_cmd == Q_WR);
        base_q <= iss_col;
        off_q  <= iss_col & (COL_W'(iss_bl) - COL_W'(1));
        bl_q   <= iss_bl;
        rem_q  <= iss_bl - BLW'(2);
        dm_q   <= 1'b0;
        wait_q <= 1'b0;
      end else begin
        if (act_q && rem_q != '0) begin
          off_q <= (off_q + COL_W'(2)) & mask;
          rem_q <= rem_q - BLW'(2);
        end else begin
          act_q <= 1'b0;
        end
        if (wait_q) cnt_q <= cnt_q - CW'(1);
        if (go_bst || go_mask) begin
          wait_q   <= 1'b1;
          cnt_q    <= t_load;
          pend_cmd <= req_cmd;
          pend_col <= req_col;
          pend_bl  <= bl_cfg;
        end
        if (go_bst) begin
          cmd_q <= C_BST;
          act_q <= 1'b0;
        end
        if (go_mask) dm_q <= 1'b1;
      end
    end
  end

  p_bl_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (bl_q == BLW'(2) || bl_q == BLW'(4) || bl_q == BLW'(8)));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && $past(act_q) && cmd_q == C_NOP) |-> (off_q == (($past(off_q) + COL_W'(2)) & mask)));

  p_upper_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && $past(act_q) && cmd_q == C_NOP) |-> ((beat_col0 & ~mask) == ($past(beat_col0) & ~mask)));

  p_bst_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_BST) |=> (cmd_q == ((T_BSTW == 1) ? C_WR : C_NOP)));

  p_bst_stops_beats_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_BST) |-> !beat_valid);

  p_dm_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != C_NOP && cmd_q != C_BST) |-> !dm);
endmodule

// File: tb/ddr_burst_seq_tb.sv
module ddr_burst_seq_tb_top;
  localparam int COL_W = 8, T_BSTW = 2, T_WRD = 3, T_DPL = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] bl_cfg = 4'd8;
  logic req_valid = 1'b0;
  logic [1:0] req_cmd = 2'd0;
  logic [COL_W-1:0] req_col = '0;
  logic req_ready, beat_valid, beat_wr, dm, busy;
  logic [2:0] mem_cmd;
  logic [COL_W-1:0] mem_col, beat_col0, beat_col1;

  always #2.5 clk = ~clk;

  ddr_burst_seq #(.COL_W(COL_W), .BLW(4), .T_BSTW(T_BSTW), .T_WRD(T_WRD), .T_DPL(T_DPL)) dut_i (
    .clk(clk), .rst_n(rst_n), .bl_cfg(bl_cfg), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_col(req_col), .req_ready(req_ready), .mem_cmd(mem_cmd), .mem_col(mem_col),
    .beat_valid(beat_valid), .beat_wr(beat_wr), .beat_col0(beat_col0), .beat_col1(beat_col1),
    .dm(dm), .busy(busy));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  string tag = "R2";

  int bq[$];
  int m_cmd = 0, m_col = 0, wcnt = 0, pc = 0, pcol = 0, pbl = 0;
  bit m_wr = 0, m_dm = 0, m_wait = 0, acc = 0;

  task automatic chk(string what, int a, int e);
    n_chk++;
    if (a != e) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, a, e);
    end
  endtask

  function automatic bit blok(int b);
    return b == 2 || b == 4 || b == 8;
  endfunction

  task automatic issue(int c, int col, int bl);
    m_cmd = c;
    m_col = (c != 3) ? col : 0;
    m_dm = 0;
    bq.delete();
    if (c != 3) begin
      m_wr = (c == 2);
      for (int k = 0; k < bl; k++) bq.push_back((col & ~(bl - 1)) | ((col + k) & (bl - 1)));
    end
  endtask

  task automatic step(bit v, int c, int col);
    bit rdy;
    int osz, t;
    @(negedge clk);
    req_valid = v;
    req_cmd = 2'(c);
    req_col = COL_W'(col);
    #1;
    rdy = !m_wait && (bq.size() != 4) && blok(int'(bl_cfg));
    chk("req_ready", int'(req_ready), int'(rdy));
    chk("mem_cmd", int'(mem_cmd), m_cmd);
    chk("mem_col", int'(mem_col), m_col);
    chk("beat_valid", int'(beat_valid), int'(bq.size() > 0));
    if (bq.size() > 0) begin
      chk("beat_col0", int'(beat_col0), bq[0]);
      chk("beat_col1", int'(beat_col1), bq[1]);
      chk("beat_wr", int'(beat_wr), int'(m_wr));
    end
    chk("dm", int'(dm), int'(m_dm && bq.size() > 0 && m_wr));
    chk("busy", int'(busy), int'(bq.size() > 0 || m_wait));
    acc = v && rdy && c != 0;
    osz = bq.size();
    if (osz > 0) begin
      void'(bq.pop_front());
      void'(bq.pop_front());
    end
    m_cmd = 0;
    m_col = 0;
    if (m_wait) begin
      if (wcnt == 1) begin
        issue(pc, pcol, pbl);
        m_wait = 0;
      end else wcnt--;
    end else if (acc) begin
      if (osz <= 2) issue(c, col, int'(bl_cfg));
      else if (!m_wr && c == 2) begin
        bq.delete();
        m_cmd = 4;
        m_wait = 1;
        wcnt = T_BSTW;
        pc = c; pcol = col; pbl = int'(bl_cfg);
      end else if (m_wr && c != 2) begin
        t = (c == 1) ? T_WRD : T_DPL;
        if (t == 1) issue(c, col, int'(bl_cfg));
        else begin
          m_dm = 1;
          m_wait = 1;
          wcnt = t - 1;
          pc = c; pcol = col; pbl = int'(bl_cfg);
        end
      end else issue(c, col, int'(bl_cfg));
    end
  endtask

  task automatic send(int c, int col);
    for (int i = 0; i < 40; i++) begin
      step(1, c, col);
      if (acc) break;
    end
    if (!acc) chk("accept", 0, 1);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R2 reset";
    chk("mem_cmd", int'(mem_cmd), 0);
    chk("beat_valid", int'(beat_valid), 0);
    chk("busy", int'(busy), 0);
    rst_n = 1'b1;
    idle(2);

    tag = "R1 illegal length";
    bl_cfg = 4'd3; step(1, 1, 0); step(1, 2, 4); idle(2);
    bl_cfg = 4'd0; step(1, 1, 0); idle(1);
    bl_cfg = 4'd9; step(1, 3, 0); idle(2);

    tag = "R3 wrap 8";
    bl_cfg = 4'd8; send(1, 8'h1D); idle(6);
    tag = "R4 wrap 4 write";
    bl_cfg = 4'd4; send(2, 8'hAE); idle(4);
    tag = "R3 wrap 2";
    bl_cfg = 4'd2; send(1, 8'h33); send(2, 8'h5A); idle(3);

    tag = "R5 read-read";
    bl_cfg = 4'd8; send(1, 8'h00); send(1, 8'h46); idle(6);
    tag = "R5 write-write";
    send(2, 8'h13); send(2, 8'hF1); idle(6);
    tag = "R5 read-precharge";
    send(1, 8'h22); send(3, 8'h00); idle(4);

    tag = "R6 read-write";
    send(1, 8'h64); send(2, 8'h61); idle(7);
    tag = "R7 write-read";
    send(2, 8'h87); send(1, 8'h82); idle(7);
    tag = "R8 write-precharge";
    send(2, 8'h91); send(3, 8'h00); idle(5);
    tag = "R11 mask then write";
    bl_cfg = 4'd4; send(2, 8'h4C); idle(1); send(1, 8'h45); idle(5);

    tag = "R9 last pair hold";
    bl_cfg = 4'd4; send(1, 8'h11); send(2, 8'h23); send(1, 8'h37); idle(4);
    bl_cfg = 4'd8; send(2, 8'h70); idle(2); send(1, 8'h0F); idle(5);

    tag = "R10 held during wait";
    send(1, 8'h50); send(2, 8'h55); send(1, 8'h5B); send(3, 8'h00); idle(6);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule